// File: doc/BRIEF.md
# Sequential Q15 Fraction Divider

This block divides one non-negative Q15 fraction by a positive Q15 fraction whose magnitude is at least as large, giving a 15-bit fractional quotient in a 16-bit word. It uses restoring shift, compare and subtract steps and resolves one quotient bit per clock cycle. A caller presents both operands with a one-cycle start pulse while the unit is idle. It then waits for a one-cycle done pulse and reads the quotient and an error flag at that point.

Two cases are settled at once, in the cycle that accepts the start. When the operands are equal, the answer is the largest Q15 value. When the operands break the input contract, the answer is zero with the error flag set. Every other pair runs the full iteration sequence.

The first quotient bit is formed in the same cycle the operands are accepted. A normal division therefore finishes 15 cycles after its start.

Top module: `q15_frac_div`

## Requirements
- R1: After reset, busy_o, done_o, err_o and quo_o are all zero.
- R2: For legal operands with num_i < den_i, the quotient is floor(num_i * 2^15 / den_i). It lies in 0x0000..0x7FFF with bit 15 zero, and err_o is 0.
- R3: A legal start with num_i < den_i gives busy_o = 1 in the 14 cycles after the start cycle. In the 15th cycle after the start cycle, done_o = 1 and busy_o = 0. busy_o and done_o are never high together.
- R4: A legal start with num_i == den_i gives done_o = 1 with quo_o = 0x7FFF and err_o = 0 in the next cycle, and busy_o never rises.
- R5: Operands are 16-bit two's complement. The inputs are illegal if num_i bit 15 is set, or den_i bit 15 is set, or den_i is zero, or num_i > den_i. An illegal start gives done_o = 1, err_o = 1 and quo_o = 0x0000 in the next cycle, without busy_o.
- R6: A start pulse while busy_o = 1 is ignored. The running division completes at its original time with its original result, and the ignored start produces no done pulse of its own.
- R7: quo_o and err_o change only in a cycle where done_o = 1. They hold their values between completions.
- R8: A start in the same cycle that done_o is high is accepted. The new division completes with its own timing and result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse, sampled with the operands |
| num_i | input | 16 | Numerator, two's complement Q15 |
| den_i | input | 16 | Denominator, two's complement Q15 |
| busy_o | output | 1 | Iteration in progress |
| done_o | output | 1 | One-cycle completion pulse |
| quo_o | output | 16 | Quotient, held between completions |
| err_o | output | 1 | Illegal operands, held with the quotient |

## Verification
Completion of one division and acceptance of the next can fall in the same cycle: the done pulse of a finishing run coincides with a new start, because busy_o has already dropped. The bench provokes this by raising start in exactly the cycle it first sees done_o. It checks that the finishing result is intact and that the new operation reports its own quotient at its own latency. A second overlap, a start arriving while iterations run, is driven with both legal and illegal operands. It is judged by the unchanged result and finish time of the running division.

// File: rtl/q15_div_pkg.sv
package q15_div_pkg;

    localparam int unsigned DEF_WIDTH = 16;
    localparam int unsigned DEF_FRAC  = 15;

    // Classification of an operand pair at the start cycle
    typedef enum logic [1:0] {
        KIND_ITERATE = 2'd0,
        KIND_EQUAL   = 2'd1,
        KIND_ILLEGAL = 2'd2
    } entry_kind_e;

    // Largest fraction with the given number of fractional bits
    function automatic logic [DEF_WIDTH-1:0] frac_max(input int unsigned frac);
        logic [DEF_WIDTH-1:0] v;
        v = '0;
        for (int i = 0; i < int'(DEF_WIDTH); i++) begin
            if (i < int'(frac)) v[i] = 1'b1;
        end
        return v;
    endfunction

endpackage

// File: rtl/q15_div_screen.sv
module q15_div_screen
    import q15_div_pkg::*;
#(
    parameter int unsigned WIDTH = DEF_WIDTH
) (
    input  logic [WIDTH-1:0] num_i,
    input  logic [WIDTH-1:0] den_i,
    output entry_kind_e      kind_o
);
    logic neg_num;
    logic bad_den;
    logic too_big;

    always_comb begin
        neg_num = num_i[WIDTH-1];
        bad_den = den_i[WIDTH-1] || (den_i == '0);
        // both non-negative here, so an unsigned compare is valid
        too_big = !neg_num && !den_i[WIDTH-1] && (num_i > den_i);
        if (neg_num || bad_den || too_big)
            kind_o = KIND_ILLEGAL;
        else if (num_i == den_i)
            kind_o = KIND_EQUAL;
        else
            kind_o = KIND_ITERATE;
    end

endmodule

// File: rtl/q15_div_step.sv
module q15_div_step #(
    parameter int unsigned WIDTH = 16,
    parameter int unsigned REM_W = 2 * WIDTH
) (
    input  logic [REM_W-1:0] rem_i,
    input  logic [WIDTH-1:0] quo_i,
    input  logic [WIDTH-1:0] den_i,
    output logic [REM_W-1:0] rem_o,
    output logic [WIDTH-1:0] quo_o
);
    logic [REM_W-1:0] doubled;
    logic [REM_W-1:0] den_ext;
    logic             fits;

    always_comb begin
        doubled = {rem_i[REM_W-2:0], 1'b0};
        den_ext = {{(REM_W-WIDTH){1'b0}}, den_i};
        fits    = (doubled >= den_ext);
        rem_o   = fits ? (doubled - den_ext) : doubled;
        quo_o   = {quo_i[WIDTH-2:0], fits};
    end

endmodule

// File: rtl/q15_div_seq.sv
module q15_div_seq
    import q15_div_pkg::*;
#(
    parameter int unsigned WIDTH     = DEF_WIDTH,
    parameter int unsigned FRAC_BITS = DEF_FRAC,
    parameter int unsigned REM_W     = 2 * WIDTH
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  entry_kind_e      kind_i,
    input  logic [WIDTH-1:0] num_i,
    input  logic [WIDTH-1:0] den_i,
    output logic [REM_W-1:0] step_rem_o,
    output logic [WIDTH-1:0] step_quo_o,
    output logic [WIDTH-1:0] step_den_o,
    input  logic [REM_W-1:0] step_rem_i,
    input  logic [WIDTH-1:0] step_quo_i,
    output logic             busy_o,
    output logic             done_o,
    output logic [WIDTH-1:0] quo_o,
    output logic             err_o
);
    localparam int unsigned CNT_W = $clog2(FRAC_BITS + 1);
    localparam logic [CNT_W-1:0] LOAD_LEFT = CNT_W'(FRAC_BITS - 1);
    localparam logic [WIDTH-1:0] MAX_QUO = frac_max(FRAC_BITS);
    localparam bit ONE_STEP = (FRAC_BITS == 1);

    logic [REM_W-1:0] rem_q;
    logic [WIDTH-1:0] acc_q;
    logic [WIDTH-1:0] den_q;
    logic [CNT_W-1:0] left_q;
    logic             accept;

    assign accept = start_i && !busy_o;

    // Load cycle feeds the operands straight into the first step
    always_comb begin
        if (busy_o) begin
            step_rem_o = rem_q;
            step_quo_o = acc_q;
            step_den_o = den_q;
        end else begin
            step_rem_o = {{(REM_W-WIDTH){1'b0}}, num_i};
            step_quo_o = '0;
            step_den_o = den_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_o <= 1'b0;
            done_o <= 1'b0;
            quo_o  <= '0;
            err_o  <= 1'b0;
            rem_q  <= '0;
            acc_q  <= '0;
            den_q  <= '0;
            left_q <= '0;
        end else begin
            done_o <= 1'b0;
            if (accept) begin
                unique case (kind_i)
                    KIND_ILLEGAL: begin
                        done_o <= 1'b1;
                        err_o  <= 1'b1;
                        quo_o  <= '0;
                    end
                    KIND_EQUAL: begin
                        done_o <= 1'b1;
                        err_o  <= 1'b0;
                        quo_o  <= MAX_QUO;
                    end
                    default: begin
                        if (ONE_STEP) begin
                            done_o <= 1'b1;
                            err_o  <= 1'b0;
                            quo_o  <= step_quo_i;
                        end else begin
                            busy_o <= 1'b1;
                            rem_q  <= step_rem_i;
                            acc_q  <= step_quo_i;
                            den_q  <= den_i;
                            left_q <= LOAD_LEFT;
                        end
                    end
                endcase
            end else if (busy_o) begin
                rem_q  <= step_rem_i;
                acc_q  <= step_quo_i;
                left_q <= left_q - 1'b1;
                if (left_q == CNT_W'(1)) begin
                    busy_o <= 1'b0;
                    done_o <= 1'b1;
                    err_o  <= 1'b0;
                    quo_o  <= step_quo_i;
                end
            end
        end
    end

endmodule

// File: rtl/q15_frac_div.sv
module q15_frac_div
    import q15_div_pkg::*;
#(
    parameter int unsigned WIDTH     = DEF_WIDTH,
    parameter int unsigned FRAC_BITS = DEF_FRAC
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [WIDTH-1:0] num_i,
    input  logic [WIDTH-1:0] den_i,
    output logic             busy_o,
    output logic             done_o,
    output logic [WIDTH-1:0] quo_o,
    output logic             err_o
);
    localparam int unsigned REM_W = 2 * WIDTH;

    entry_kind_e      kind;
    logic [REM_W-1:0] s_rem_in;
    logic [REM_W-1:0] s_rem_out;
    logic [WIDTH-1:0] s_quo_in;
    logic [WIDTH-1:0] s_quo_out;
    logic [WIDTH-1:0] s_den;

    q15_div_screen #(.WIDTH(WIDTH)) u_screen (
        .num_i  (num_i),
        .den_i  (den_i),
        .kind_o (kind)
    );

    q15_div_step #(.WIDTH(WIDTH), .REM_W(REM_W)) u_step (
        .rem_i (s_rem_in),
        .quo_i (s_quo_in),
        .den_i (s_den),
        .rem_o (s_rem_out),
        .quo_o (s_quo_out)
    );

    q15_div_seq #(.WIDTH(WIDTH), .FRAC_BITS(FRAC_BITS), .REM_W(REM_W)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_i),
        .kind_i     (kind),
        .num_i      (num_i),
        .den_i      (den_i),
        .step_rem_o (s_rem_in),
        .step_quo_o (s_quo_in),
        .step_den_o (s_den),
        .step_rem_i (s_rem_out),
        .step_quo_i (s_quo_out),
        .busy_o     (busy_o),
        .done_o     (done_o),
        .quo_o      (quo_o),
        .err_o      (err_o)
    );

endmodule

// File: rtl/q15_div_chk.sv
module q15_div_chk #(
    parameter int unsigned WIDTH     = 16,
    parameter int unsigned FRAC_BITS = 15
) (
    input logic             clk,
    input logic             rst,
    input logic             start_i,
    input logic [WIDTH-1:0] num_i,
    input logic [WIDTH-1:0] den_i,
    input logic             busy_o,
    input logic             done_o,
    input logic [WIDTH-1:0] quo_o,
    input logic             err_o
);
    localparam int unsigned SPAN_W = $clog2(FRAC_BITS + 2) + 1;
    localparam logic [SPAN_W-1:0] SPAN_MAX = '1;

    logic             taken;
    logic             legal;
    logic [SPAN_W-1:0] since;

    assign taken = start_i && !busy_o;
    assign legal = !num_i[WIDTH-1] && !den_i[WIDTH-1] && (den_i != '0) && (num_i <= den_i);

    // cycles since the last accepted start, saturating
    always_ff @(posedge clk) begin
        if (rst)
            since <= SPAN_MAX;
        else if (taken)
            since <= SPAN_W'(1);
        else if (since != SPAN_MAX)
            since <= since + 1'b1;
    end

    // R3
    busy_done_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(busy_o && done_o));

    // R3
    done_latency_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (since == SPAN_W'(1) || since == SPAN_W'(FRAC_BITS)));

    // R2
    quo_top_clear_chk: assert property (@(posedge clk) disable iff (rst)
        quo_o[WIDTH-1] == 1'b0);

    // R4
    equal_fast_chk: assert property (@(posedge clk) disable iff (rst)
        (taken && legal && num_i == den_i) |=> (done_o && !busy_o && !err_o
                                                 && quo_o == WIDTH'((1 << FRAC_BITS) - 1)));

    // R5
    illegal_fast_chk: assert property (@(posedge clk) disable iff (rst)
        (taken && !legal) |=> (done_o && err_o && !busy_o && quo_o == '0));

    // R5
    err_zero_chk: assert property (@(posedge clk) disable iff (rst)
        err_o |-> (quo_o == '0));

    // R7
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> ($stable(quo_o) && $stable(err_o)));

    // R6
    busy_persist_chk: assert property (@(posedge clk) disable iff (rst)
        busy_o |=> (busy_o || done_o));

endmodule

bind q15_frac_div q15_div_chk #(.WIDTH(WIDTH), .FRAC_BITS(FRAC_BITS)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .start_i (start_i),
    .num_i   (num_i),
    .den_i   (den_i),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .quo_o   (quo_o),
    .err_o   (err_o)
);

// File: tb/q15_frac_div_bench.sv
module q15_frac_div_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [15:0] num_i = '0;
    logic [15:0] den_i = '0;
    logic        busy_o;
    logic        done_o;
    logic [15:0] quo_o;
    logic        err_o;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    q15_frac_div u_q15_frac_div (
        .clk(clk), .rst(rst), .start_i(start_i), .num_i(num_i), .den_i(den_i),
        .busy_o(busy_o), .done_o(done_o), .quo_o(quo_o), .err_o(err_o)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic bit is_illegal(input logic [15:0] n, input logic [15:0] d);
        return n[15] || d[15] || (d == 16'h0) || (n > d);
    endfunction

    function automatic logic [15:0] ref_quo(input logic [15:0] n, input logic [15:0] d);
        int unsigned wide;
        if (is_illegal(n, d)) return 16'h0000;
        if (n == d) return 16'h7FFF;
        wide = (32'(n) << 15) / 32'(d);
        return wide[15:0];
    endfunction

    function automatic int ref_lat(input logic [15:0] n, input logic [15:0] d);
        if (is_illegal(n, d) || n == d) return 1;
        return 15;
    endfunction

    // drive start for one cycle from a negedge, returns at the next negedge
    task automatic launch(input logic [15:0] n, input logic [15:0] d);
        start_i = 1'b1; num_i = n; den_i = d;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    // wait for done, lat counts negedges since the start cycle
    task automatic await_check(input logic [15:0] n, input logic [15:0] d,
                               input int lat0, input string tag);
        int lat = lat0;
        bit busy_ok = 1'b1;
        while (!done_o && lat < 40) begin
            if (!busy_o) busy_ok = 1'b0;
            @(negedge clk);
            lat++;
        end
        check(lat == ref_lat(n, d), {tag, " R3 latency"}, lat, ref_lat(n, d));
        if (ref_lat(n, d) == 15)
            check(busy_ok, {tag, " R3 busy held"}, busy_ok, 1);
        check(quo_o == ref_quo(n, d), {tag, " R2 quotient"}, quo_o, ref_quo(n, d));
        check(err_o == is_illegal(n, d), {tag, " R5 err"}, err_o, is_illegal(n, d));
        check(!busy_o, {tag, " R3 busy low at done"}, busy_o, 0);
    endtask

    task automatic run_op(input logic [15:0] n, input logic [15:0] d, input string tag);
        launch(n, d);
        await_check(n, d, 1, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [15:0] hq;
        logic        he;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(!busy_o && !done_o && !err_o && quo_o == 16'h0, "R1 reset state",
              {busy_o, done_o, err_o, quo_o}, 0);

        // directed corner cases
        run_op(16'h4000, 16'h4000, "R4 equal");
        check(1'b1, "R4 equal run", 0, 0);
        run_op(16'h0001, 16'h0001, "R4 equal min");
        run_op(16'h0000, 16'h7FFF, "R2 zero num");
        run_op(16'h7FFE, 16'h7FFF, "R2 near one");
        run_op(16'h0001, 16'h7FFF, "R2 tiny");
        run_op(16'h2000, 16'h4000, "R2 half");
        run_op(16'h0000, 16'h0000, "R5 zero den");
        run_op(16'h8000, 16'h4000, "R5 neg num");
        run_op(16'h1000, 16'hF000, "R5 neg den");
        run_op(16'h5000, 16'h4000, "R5 num gt den");

        // R7 hold after completion
        hq = quo_o; he = err_o;
        run_op(16'h1234, 16'h5678, "R7 setup");
        hq = quo_o; he = err_o;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            check(!done_o && quo_o == hq && err_o == he, "R7 hold", quo_o, hq);
        end

        // R6 start while busy ignored
        launch(16'h0100, 16'h0300);
        begin
            int lat = 1;
            for (int i = 0; i < 4; i++) begin
                start_i = 1'b1;
                num_i = (i % 2 == 0) ? 16'h0300 : 16'h8000;
                den_i = 16'h0300;
                @(negedge clk);
                lat++;
            end
            start_i = 1'b0;
            await_check(16'h0100, 16'h0300, lat, "R6 ignored start");
        end
        @(negedge clk);
        check(!done_o, "R6 no extra done", done_o, 0);

        // R8 back-to-back: new start in the done cycle
        launch(16'h0AAA, 16'h3333);
        await_check(16'h0AAA, 16'h3333, 1, "R8 first");
        launch(16'h0555, 16'h7000);
        await_check(16'h0555, 16'h7000, 1, "R8 second");
        launch(16'h0800, 16'h0800);
        await_check(16'h0800, 16'h0800, 1, "R8 equal chained");
        launch(16'h0900, 16'h0800);
        await_check(16'h0900, 16'h0800, 1, "R8 illegal chained");

        // constrained random mix
        for (int k = 0; k < 300; k++) begin
            logic [15:0] n;
            logic [15:0] d;
            int sel = int'($urandom % 10);
            d = 16'(1 + ($urandom % 32767));
            n = 16'($urandom % (32'(d) + 1));
            if (sel == 0) n = d;
            else if (sel == 1) begin
                unique case ($urandom % 4)
                    0: n = n | 16'h8000;
                    1: d = 16'h0000;
                    2: d = d | 16'h8000;
                    default: begin d = 16'(1 + ($urandom % 32766)); n = d + 16'd1; end
                endcase
            end
            run_op(n, d, "R2 random");
        end

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule